// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer with Byte-Lane Decode

This block connects a simple peripheral to a 16-bit bus that carries address and data on the same lines. One bus cycle has two phases. While the bus clock E is low, the shared lines carry the address. While E is high, they carry data. The block samples E, R/W, the active-low low-strobe and the shared lines on its own system clock, and detects the E edges in those samples.

On each rising E edge the block latches the address, the direction and the strobe. From address bit 0 and the strobe it derives the even-lane and odd-lane enables, or an illegal-access flag. It compares the upper address bits with a configured base value to form a chip select. On the falling E edge of a selected write, it captures the data into a one-entry output register. On a selected read, it raises a one-cycle request for the peripheral, then drives the peripheral's read data onto the enabled byte lanes for as long as the data phase lasts.

The write path is valid/ready. Once `wr_valid` rises, it stays high and `wr_addr`, `wr_data` and `wr_be` stay unchanged until a clock edge that sees `wr_ready` high. The bus itself cannot be stalled. The peripheral must therefore accept a captured write before the falling E edge of the next write to this block. A newer capture replaces an entry that has not been taken.

Top module: `mbus_demux`

## Requirements
- R1: On the first system clock after a rising E edge is seen, `rd_addr`/`wr_addr` hold the bus value that was sampled while E was still low, two samples before the edge was detected. The latched address does not change again until the next rising edge.
- R2: On a falling E edge that ends a selected, legal write (`bus_rw` = 0), `wr_data` takes the last value sampled while E was high, and `wr_be` = {even, odd} lane enables.
- R3: During the data phase, address bit 0 = 0 with strobe = 0 enables both lanes. Bit 0 = 0 with strobe = 1 enables only the even lane (AD[15:8]). Bit 0 = 1 with strobe = 0 enables only the odd lane (AD[7:0]).
- R4: Address bit 0 = 1 with strobe = 1 raises `lane_err` during the data phase, enables no lane, drives nothing and captures no write.
- R5: `chip_sel` is 1 exactly when latched address bits [15:12] equal `cs_base`.
- R6: `bus_ad_oe` is 1 only during the data phase of a selected, legal read (`bus_rw` = 1). It falls within two system clocks after E falls.
- R7: While `bus_ad_oe` is 1, `bus_ad_out[15:8]` carries `rd_data[15:8]` if the even lane is enabled, and otherwise 0. `bus_ad_out[7:0]` carries `rd_data[7:0]` if the odd lane is enabled, and otherwise 0.
- R8: `wr_valid` stays high with stable `wr_data` until a clock edge that sees `wr_ready` high. It then clears, unless a new write is captured on that same edge.
- R9: `rd_req` is a single-cycle pulse issued with the latched address at the start of a selected, legal read.
- R10: After reset, all lane, select, request, valid and output-enable outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than E |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Bus phase clock: low = address, high = data |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_lstrb | input | 1 | Active-low low-byte strobe |
| bus_ad_in | input | 16 | Shared address/data lines as seen by the block |
| bus_ad_out | output | 16 | Read data for the shared lines |
| bus_ad_oe | output | 1 | Output enable for `bus_ad_out` |
| cs_base | input | 4 | Base value matched against address bits [15:12] |
| lane_even | output | 1 | Even (high) byte lane enabled in this data phase |
| lane_odd | output | 1 | Odd (low) byte lane enabled in this data phase |
| lane_err | output | 1 | Illegal bit0/strobe combination in this data phase |
| chip_sel | output | 1 | Latched address falls in this block's range |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 16 | Latched address |
| rd_data | input | 16 | Read data from the peripheral |
| wr_valid | output | 1 | Captured write pending |
| wr_ready | input | 1 | Peripheral accepts the pending write |
| wr_addr | output | 16 | Address of the pending write |
| wr_data | output | 16 | Data of the pending write |
| wr_be | output | 2 | Lane enables of the pending write, {even, odd} |

## Verification
The assertions take the following for granted about the inputs:
- Each E phase lasts at least two system clocks.
- The shared lines, R/W and the strobe settle before each E edge.
- `rd_data` stays stable through each data phase.
- A pending write is accepted before the next falling E edge that captures a write; the hold check is suspended on capture edges.

The stimulus keeps to these rules in the following way:
- Every low phase lasts at least four clocks and every high phase at least three.
- Address and data are placed on the lines at the start of their phase.
- `rd_data` changes only late in a low phase, when no output is enabled.
- `wr_ready` is held low only between writes.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    LN_WORD = 2'd0,
    LN_EVEN = 2'd1,
    LN_ODD  = 2'd2,
    LN_BAD  = 2'd3
  } lane_sel_e;

  typedef struct packed {
    logic even;
    logic odd;
    logic bad;
  } lane_t;

  function automatic lane_sel_e lane_decode(input logic a0, input logic strobe_n);
    unique case ({a0, strobe_n})
      2'b00:   return LN_WORD;
      2'b01:   return LN_EVEN;
      2'b10:   return LN_ODD;
      default: return LN_BAD;
    endcase
  endfunction

  function automatic lane_t lane_flags(input lane_sel_e sel);
    lane_t f;
    f = '0;
    case (sel)
      LN_WORD: begin f.even = 1'b1; f.odd = 1'b1; end
      LN_EVEN: f.even = 1'b1;
      LN_ODD:  f.odd  = 1'b1;
      default: f.bad  = 1'b1;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/mbus_sampler.sv
module mbus_sampler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         e_in,
  input  logic         rw_in,
  input  logic         strobe_n_in,
  input  logic [W-1:0] ad_in,
  output logic         e_rise,
  output logic         e_fall,
  output logic         rw_prev,
  output logic         strobe_n_prev,
  output logic [W-1:0] ad_prev
);

  logic e_now, e_old;
  logic rw_now, strobe_now;
  logic [W-1:0] ad_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_now         <= 1'b0;
      e_old         <= 1'b0;
      rw_now        <= 1'b0;
      rw_prev       <= 1'b0;
      strobe_now    <= 1'b0;
      strobe_n_prev <= 1'b0;
      ad_now        <= '0;
      ad_prev       <= '0;
    end else begin
      e_now         <= e_in;
      e_old         <= e_now;
      rw_now        <= rw_in;
      rw_prev       <= rw_now;
      strobe_now    <= strobe_n_in;
      strobe_n_prev <= strobe_now;
      ad_now        <= ad_in;
      ad_prev       <= ad_now;
    end
  end

  assign e_rise = e_now & ~e_old;
  assign e_fall = ~e_now & e_old;

endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
  import mbus_pkg::*;
#(
  parameter int W      = 16,
  parameter int CS_LSB = 12,
  localparam int BW    = W - CS_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          e_rise,
  input  logic          e_fall,
  input  logic          rw_prev,
  input  logic          strobe_n_prev,
  input  logic [W-1:0]  ad_prev,
  input  logic [BW-1:0] cs_base,
  output logic [W-1:0]  addr_q,
  output logic          rw_q,
  output logic          phase_q,
  output logic          cs,
  output logic          lane_even,
  output logic          lane_odd,
  output logic          lane_bad,
  output logic          rd_req
);

  logic      strobe_q;
  lane_t     flags;
  lane_t     flags_next;
  logic      cs_next;

  assign flags      = lane_flags(lane_decode(addr_q[0], strobe_q));
  assign flags_next = lane_flags(lane_decode(ad_prev[0], strobe_n_prev));
  assign cs         = (addr_q[W-1:CS_LSB] == cs_base);
  assign cs_next    = (ad_prev[W-1:CS_LSB] == cs_base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      rw_q     <= 1'b0;
      strobe_q <= 1'b0;
      phase_q  <= 1'b0;
      rd_req   <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      if (e_rise) begin
        addr_q   <= ad_prev;
        rw_q     <= rw_prev;
        strobe_q <= strobe_n_prev;
        phase_q  <= 1'b1;
        rd_req   <= rw_prev & cs_next & ~flags_next.bad;
      end else if (e_fall) begin
        phase_q  <= 1'b0;
      end
    end
  end

  assign lane_even = phase_q & flags.even;
  assign lane_odd  = phase_q & flags.odd;
  assign lane_bad  = phase_q & flags.bad;

  // R3: a legal data phase always enables at least one lane
  a_r3_lane_present: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && !lane_bad) |-> (lane_even || lane_odd));

  // R9: read request lasts a single cycle
  a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

endmodule

// File: rtl/mbus_wr_capture.sv
module mbus_wr_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         e_fall,
  input  logic         phase_q,
  input  logic         rw_q,
  input  logic         cs,
  input  logic         lane_even,
  input  logic         lane_odd,
  input  logic         lane_bad,
  input  logic [W-1:0] addr_q,
  input  logic [W-1:0] ad_prev,
  input  logic         wr_ready,
  output logic         wr_valid,
  output logic [W-1:0] wr_addr,
  output logic [W-1:0] wr_data,
  output logic [1:0]   wr_be
);

  logic cap;
  assign cap = e_fall & phase_q & ~rw_q & cs & ~lane_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else if (cap) begin
      wr_valid <= 1'b1;
      wr_addr  <= addr_q;
      wr_data  <= ad_prev;
      wr_be    <= {lane_even, lane_odd};
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // R8: a pending write is held until it is accepted
  a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !cap) |=> (wr_valid && $stable(wr_data)));

endmodule

// File: rtl/mbus_rd_drive.sv
module mbus_rd_drive #(
  parameter int W   = 16,
  localparam int LW = W / 2
) (
  input  logic         phase_q,
  input  logic         rw_q,
  input  logic         cs,
  input  logic         lane_even,
  input  logic         lane_odd,
  input  logic         lane_bad,
  input  logic [W-1:0] rd_data,
  output logic         ad_oe,
  output logic [W-1:0] ad_out
);

  logic [1:0] lane_on;
  assign lane_on = {lane_even, lane_odd};
  assign ad_oe   = phase_q & rw_q & cs & ~lane_bad;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign ad_out[i*LW +: LW] = (ad_oe && lane_on[i]) ? rd_data[i*LW +: LW] : '0;
  end

endmodule

// File: rtl/mbus_demux.sv
module mbus_demux #(
  parameter int W      = 16,
  parameter int CS_LSB = 12,
  localparam int BW    = W - CS_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_e,
  input  logic          bus_rw,
  input  logic          bus_lstrb,
  input  logic [W-1:0]  bus_ad_in,
  output logic [W-1:0]  bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [BW-1:0] cs_base,
  output logic          lane_even,
  output logic          lane_odd,
  output logic          lane_err,
  output logic          chip_sel,
  output logic          rd_req,
  output logic [W-1:0]  rd_addr,
  input  logic [W-1:0]  rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [W-1:0]  wr_addr,
  output logic [W-1:0]  wr_data,
  output logic [1:0]    wr_be
);

  logic         e_rise, e_fall, rw_prev, strobe_n_prev;
  logic [W-1:0] ad_prev;
  logic [W-1:0] addr_q;
  logic         rw_q, phase_q, cs;

  mbus_sampler #(.W(W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .e_in(bus_e), .rw_in(bus_rw),
    .strobe_n_in(bus_lstrb), .ad_in(bus_ad_in),
    .e_rise(e_rise), .e_fall(e_fall), .rw_prev(rw_prev),
    .strobe_n_prev(strobe_n_prev), .ad_prev(ad_prev)
  );

  mbus_addr_latch #(.W(W), .CS_LSB(CS_LSB)) u_latch (
    .clk(clk), .rst_n(rst_n), .e_rise(e_rise), .e_fall(e_fall),
    .rw_prev(rw_prev), .strobe_n_prev(strobe_n_prev), .ad_prev(ad_prev),
    .cs_base(cs_base), .addr_q(addr_q), .rw_q(rw_q), .phase_q(phase_q),
    .cs(cs), .lane_even(lane_even), .lane_odd(lane_odd),
    .lane_bad(lane_err), .rd_req(rd_req)
  );

  mbus_wr_capture #(.W(W)) u_wr (
    .clk(clk), .rst_n(rst_n), .e_fall(e_fall), .phase_q(phase_q),
    .rw_q(rw_q), .cs(cs), .lane_even(lane_even), .lane_odd(lane_odd),
    .lane_bad(lane_err), .addr_q(addr_q), .ad_prev(ad_prev),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  mbus_rd_drive #(.W(W)) u_rd (
    .phase_q(phase_q), .rw_q(rw_q), .cs(cs), .lane_even(lane_even),
    .lane_odd(lane_odd), .lane_bad(lane_err), .rd_data(rd_data),
    .ad_oe(bus_ad_oe), .ad_out(bus_ad_out)
  );

  assign chip_sel = cs;
  assign rd_addr  = addr_q;

  // R4: an illegal combination enables no lane and drives nothing
  a_r4_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    lane_err |-> (!lane_even && !lane_odd && !bus_ad_oe));

  // R6: the lines are driven only while E was high two samples earlier
  a_r6_drive_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> $past(bus_e, 2));

endmodule

// File: tb/mbus_demux_test.sv
module mbus_demux_test;
  localparam int W = 16, CS_LSB = 12, BW = W - CS_LSB;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic bus_e = 0, bus_rw = 0, bus_lstrb = 0, wr_ready = 1;
  logic [W-1:0] bus_ad_in = '0, rd_data = '0;
  logic [BW-1:0] cs_base = 4'h8;
  logic [W-1:0] bus_ad_out, rd_addr, wr_addr, wr_data;
  logic bus_ad_oe, lane_even, lane_odd, lane_err, chip_sel, rd_req, wr_valid;
  logic [1:0] wr_be;

  mbus_demux #(.W(W), .CS_LSB(CS_LSB)) uut (.*);

  integer checks = 0, fails = 0;
  bit done = 0, run_cmp = 0;

  // behavioural reference: input history and modelled state
  logic h_e0, h_e1, h_rw0, h_rw1, h_ls0, h_ls1;
  logic [W-1:0] h_ad0, h_ad1;
  logic m_phase, m_rw, m_ls, m_rdreq, m_wv;
  logic [W-1:0] m_addr, m_wa, m_wd;
  logic [1:0] m_wbe;
  logic rise, fall;

  function automatic bit sel_of(input logic [W-1:0] a);
    return a[15:12] == cs_base;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {h_e0, h_e1, h_rw0, h_rw1, h_ls0, h_ls1} = '0;
      h_ad0 = '0; h_ad1 = '0;
      {m_phase, m_rw, m_ls, m_rdreq, m_wv} = '0;
      m_addr = '0; m_wa = '0; m_wd = '0; m_wbe = '0;
    end else begin
      rise = h_e0 && !h_e1;
      fall = !h_e0 && h_e1;
      if (m_wv && wr_ready) m_wv = 0;
      if (fall && m_phase && !m_rw && sel_of(m_addr) && !(m_addr[0] && m_ls)) begin
        m_wv = 1; m_wa = m_addr; m_wd = h_ad1;
        m_wbe = {!m_addr[0], !m_ls};
      end
      m_rdreq = 0;
      if (rise) begin
        m_addr = h_ad1; m_rw = h_rw1; m_ls = h_ls1; m_phase = 1;
        m_rdreq = m_rw && sel_of(m_addr) && !(m_addr[0] && m_ls);
      end else if (fall) m_phase = 0;
      h_e1 = h_e0; h_rw1 = h_rw0; h_ls1 = h_ls0; h_ad1 = h_ad0;
      h_e0 = bus_e; h_rw0 = bus_rw; h_ls0 = bus_lstrb; h_ad0 = bus_ad_in;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp && !done) begin
      logic ev, od, er, cs_e, oe_e;
      logic [W-1:0] out_e;
      ev = m_phase && !m_addr[0];
      od = m_phase && !m_ls;
      er = m_phase && m_addr[0] && m_ls;
      cs_e = sel_of(m_addr);
      oe_e = m_phase && m_rw && cs_e && !(m_addr[0] && m_ls);
      out_e = {ev ? rd_data[15:8] : 8'h00, od ? rd_data[7:0] : 8'h00};
      chk(lane_even === ev, "R3 even lane", lane_even, ev);
      chk(lane_odd === od, "R3 odd lane", lane_odd, od);
      chk(lane_err === er, "R4 illegal flag", lane_err, er);
      chk(chip_sel === cs_e, "R5 chip select", chip_sel, cs_e);
      chk(bus_ad_oe === oe_e, "R6 output enable", bus_ad_oe, oe_e);
      if (oe_e) chk(bus_ad_out === out_e, "R7 read lanes", bus_ad_out, out_e);
      chk(rd_req === m_rdreq, "R9 read request", rd_req, m_rdreq);
      chk(rd_addr === m_addr, "R1 latched address", rd_addr, m_addr);
      chk(wr_valid === m_wv, "R8 write valid", wr_valid, m_wv);
      if (m_wv) begin
        chk(wr_data === m_wd, "R2 write data", wr_data, m_wd);
        chk(wr_be === m_wbe, "R2 write lanes", wr_be, m_wbe);
        chk(wr_addr === m_wa, "R1 write address", wr_addr, m_wa);
      end
    end
  end

  task automatic bus_cycle(input logic [W-1:0] a, input logic rw, input logic ls,
                           input logic [W-1:0] d, input logic [W-1:0] rdv,
                           input int lo, input int hi);
    for (int i = 0; i < lo; i++) begin
      @(negedge clk);
      bus_e = 0;
      if (i == 0) begin bus_ad_in = a; bus_rw = rw; bus_lstrb = ls; end
      if (i == 3) rd_data = rdv;
    end
    for (int i = 0; i < hi; i++) begin
      @(negedge clk);
      bus_e = 1;
      if (i == 0) bus_ad_in = rw ? 16'h0000 : d;
    end
    @(negedge clk);
    bus_e = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk({lane_even, lane_odd, lane_err, rd_req, wr_valid, bus_ad_oe} === 6'b0,
        "R10 reset outputs", {lane_even, lane_odd, lane_err, rd_req, wr_valid, bus_ad_oe}, 0);
    run_cmp = 1;
    bus_cycle(16'h8010, 0, 0, 16'h1234, 16'h0, 4, 4);   // word write
    bus_cycle(16'h8020, 0, 1, 16'hBEEF, 16'h0, 5, 3);   // even write
    bus_cycle(16'h8031, 0, 0, 16'h00C3, 16'h0, 4, 5);   // odd write
    bus_cycle(16'h8041, 0, 1, 16'hDEAD, 16'h0, 4, 4);   // illegal write
    bus_cycle(16'h8100, 1, 0, 16'h0, 16'hA55A, 4, 4);   // word read
    bus_cycle(16'h8102, 1, 1, 16'h0, 16'h7E81, 6, 3);   // even read
    bus_cycle(16'h8103, 1, 0, 16'h0, 16'h3CC3, 4, 6);   // odd read
    bus_cycle(16'h8105, 1, 1, 16'h0, 16'hFFFF, 4, 4);   // illegal read
    bus_cycle(16'h4000, 1, 0, 16'h0, 16'h1111, 4, 4);   // unselected read
    bus_cycle(16'h4002, 0, 0, 16'h9999, 16'h0, 4, 4);   // unselected write
    @(negedge clk); wr_ready = 0;
    bus_cycle(16'h8FFE, 0, 0, 16'h5AA5, 16'h0, 4, 4);   // write with back-pressure
    repeat (6) @(negedge clk);
    chk(wr_valid === 1'b1 && wr_data === 16'h5AA5, "R8 held while not ready", wr_data, 16'h5AA5);
    wr_ready = 1;
    @(negedge clk);
    @(negedge clk);
    chk(wr_valid === 1'b0, "R8 cleared after accept", wr_valid, 0);
    bus_cycle(16'hF000, 0, 0, 16'h0000, 16'h0, 4, 4);   // outside range
    cs_base = 4'hF;
    bus_cycle(16'hF001, 1, 0, 16'h0, 16'h2468, 4, 4);   // new base, odd read
    repeat (6) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule